// File: doc/BRIEF.md
# GPIO Interrupt Routing Mux

Three GPIO controllers, called A, B and C here, have 14, 24 and 32 interrupt lines, 70 in all. The interrupt controller downstream has only 41 inputs for them, so this block chooses which GPIO lines get an input of their own. The other lines share an input with the rest of their controller's lines.

A 32-bit control register sets up the routing. Each bit joins one line of controller A or B to one fixed line of controller C. One line of the pair drives a direct output. The other line is ORed into its controller's shared output.

Six lines of controller B do not go through the pairing. They always drive their own direct outputs. Software writes the register through a simple register port and can read it back. The routing logic after the register is purely combinational.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset the control register reads 0. Every controller A line and controller B lines 0..17 then drive direct outputs, and every controller C line is routed to shared output 2.
- R2: A write with `wr_en` high and `addr` = 0x54 stores `wdata`. From the next clock edge, reads of 0x54 return that value and the routing follows it.
- R3: A read of any address other than 0x54 returns 0. A write to any address other than 0x54 changes neither the register nor the routing.
- R4: For control bit k in 0..13, `irq_direct[k]` carries C line k when the bit is 1 and A line k when it is 0.
- R5: For control bit k in 14..31, `irq_direct[k]` carries C line k when the bit is 1 and B line k-14 when it is 0.
- R6: `irq_direct[32+j]` always carries B line 18+j, for j in 0..5, whatever the control value.
- R7: `irq_shared[0]` is the OR of the A lines whose control bit is 1. `irq_shared[1]` is the OR of B lines 0..17 whose control bit (14 + line) is 1. `irq_shared[2]` is the OR of the C lines whose control bit is 0.
- R8: A line that is routed to a shared output has no effect on any direct output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from `addr` |
| irq_a | input | 14 | Controller A interrupt lines |
| irq_b | input | 24 | Controller B interrupt lines |
| irq_c | input | 32 | Controller C interrupt lines |
| irq_direct | output | 38 | Dedicated interrupt outputs |
| irq_shared | output | 3 | Per-controller shared interrupt outputs (A, B, C) |

## Verification
The hardest case to reach is a single line active on the side of a pair that is not selected. It must show up only on its controller's shared output, and no direct output may move. A wide OR would hide that. The bench therefore walks a single active bit across all 70 inputs under two complementary control values, so every line is seen once in direct mode and once in shared mode. It also drives dense mixed patterns and writes to a neighbouring address.

// File: rtl/gpio_irq_router.sv
module gpio_irq_router #(
  parameter int A_LINES = 14,
  parameter int B_LINES = 24,
  parameter int C_LINES = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h54
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [C_LINES-1:0]          wdata,
  output logic [C_LINES-1:0]          rdata,
  input  logic [A_LINES-1:0]          irq_a,
  input  logic [B_LINES-1:0]          irq_b,
  input  logic [C_LINES-1:0]          irq_c,
  output logic [C_LINES+B_LINES-(C_LINES-A_LINES)-1:0] irq_direct,
  output logic [2:0]                  irq_shared
);
  localparam int B_MUXED  = C_LINES - A_LINES;
  localparam int B_FIXED  = B_LINES - B_MUXED;
  localparam int DIRECT_N = C_LINES + B_FIXED;

  logic [C_LINES-1:0] ctrl;
  logic [C_LINES-1:0] low_side;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ctrl <= '0;
    else if (wr_en && addr == CTRL_ADDR)
      ctrl <= wdata;
  end

  assign rdata    = (addr == CTRL_ADDR) ? ctrl : '0;
  assign low_side = {irq_b[B_MUXED-1:0], irq_a};

  assign irq_direct[C_LINES-1:0]        = (ctrl & irq_c) | (~ctrl & low_side);
  assign irq_direct[DIRECT_N-1:C_LINES] = irq_b[B_LINES-1:B_MUXED];

  assign irq_shared[0] = |(irq_a & ctrl[A_LINES-1:0]);
  assign irq_shared[1] = |(irq_b[B_MUXED-1:0] & ctrl[C_LINES-1:A_LINES]);
  assign irq_shared[2] = |(irq_c & ~ctrl);
endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk #(
  parameter int A_LINES = 14,
  parameter int B_LINES = 24,
  parameter int C_LINES = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h54
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [C_LINES-1:0]   wdata,
  input logic [C_LINES-1:0]   rdata,
  input logic [A_LINES-1:0]   irq_a,
  input logic [B_LINES-1:0]   irq_b,
  input logic [C_LINES-1:0]   irq_c,
  input logic [C_LINES+B_LINES-(C_LINES-A_LINES)-1:0] irq_direct,
  input logic [2:0]           irq_shared
);
  localparam int B_MUXED = C_LINES - A_LINES;

  // R2
  write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CTRL_ADDR) |=> (addr != CTRL_ADDR || rdata == $past(wdata)));

  // R3
  other_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != CTRL_ADDR) |-> (rdata == '0));

  // R6
  fixed_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_direct[C_LINES+B_LINES-B_MUXED-1:C_LINES] == irq_b[B_LINES-1:B_MUXED]);

  // R7
  shared_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a == '0 && irq_b == '0 && irq_c == '0) |-> (irq_shared == 3'b000));

  // R8
  direct_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a == '0 && irq_b == '0 && irq_c == '0) |-> (irq_direct == '0));
endmodule

bind gpio_irq_router gpio_irq_router_chk #(
  .A_LINES(A_LINES), .B_LINES(B_LINES), .C_LINES(C_LINES),
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
) u_chk (.*);

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb;
  localparam logic [7:0] CTRL = 8'h54;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = CTRL;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [13:0] irq_a = '0;
  logic [23:0] irq_b = '0;
  logic [31:0] irq_c = '0;
  logic [37:0] irq_direct;
  logic [2:0]  irq_shared;

  gpio_irq_router u_dut (.*);

  always #4 clk = ~clk;

  typedef struct { logic [37:0] d; logic [2:0] s; string tag; } exp_t;
  exp_t        sb[$];
  logic [31:0] shadow = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  function automatic exp_t model(logic [31:0] c_reg, logic [13:0] a,
                                 logic [23:0] b, logic [31:0] c, string tag);
    exp_t e;
    e.d = '0; e.s = '0; e.tag = tag;
    for (int k = 0; k < 14; k++)            // R4
      if (c_reg[k]) begin e.d[k] = c[k]; e.s[0] |= a[k]; end
      else          begin e.d[k] = a[k]; e.s[2] |= c[k]; end
    for (int k = 14; k < 32; k++)           // R5
      if (c_reg[k]) begin e.d[k] = c[k]; e.s[1] |= b[k-14]; end
      else          begin e.d[k] = b[k-14]; e.s[2] |= c[k]; end
    for (int j = 0; j < 6; j++) e.d[32+j] = b[18+j];  // R6
    return e;
  endfunction

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_chk++;
      if (irq_direct !== e.d || irq_shared !== e.s) begin
        n_fail++;
        $display("FAIL %s: direct=%h shared=%b expected direct=%h shared=%b",
                 e.tag, irq_direct, irq_shared, e.d, e.s);
      end
    end
  end

  task automatic apply(logic [13:0] a, logic [23:0] b, logic [31:0] c, string tag);
    @(posedge clk); #1;
    irq_a = a; irq_b = b; irq_c = c;
    sb.push_back(model(shadow, a, b, c, tag));
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [7:0] ad, logic [31:0] v);
    @(posedge clk); #1;
    wr_en = 1'b1; addr = ad; wdata = v;
    @(posedge clk); #1;
    wr_en = 1'b0; addr = CTRL;
    if (ad == CTRL) shadow = v;
  endtask

  task automatic rd(logic [7:0] ad, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    addr = ad;
    @(negedge clk);
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%h expected=%h", tag, rdata, exp);
    end
    #1 addr = CTRL;
  endtask

  task automatic walk(string tag);
    for (int i = 0; i < 14; i++) apply(14'(1) << i, '0, '0, tag);
    for (int i = 0; i < 24; i++) apply('0, 24'(1) << i, '0, tag);
    for (int i = 0; i < 32; i++) apply('0, '0, 32'(1) << i, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(CTRL, 32'h0, "R1 reset readback");
    apply('1, '0, '0, "R1 reset A direct");
    apply('0, '1, '0, "R1 reset B direct");
    apply('0, '0, '1, "R1 reset C shared");

    // Write takes effect at the next edge
    @(posedge clk); #1;
    wr_en = 1'b1; addr = CTRL; wdata = 32'hFFFF_FFFF;
    irq_a = '0; irq_b = '0; irq_c = 32'h1;
    @(negedge clk);
    n_chk++;
    if (irq_direct[0] !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 before edge: direct0=%b expected=0", irq_direct[0]);
    end
    @(posedge clk); #1;
    wr_en = 1'b0; shadow = 32'hFFFF_FFFF;
    @(negedge clk);
    n_chk++;
    if (irq_direct[0] !== 1'b1) begin
      n_fail++;
      $display("FAIL R2 after edge: direct0=%b expected=1", irq_direct[0]);
    end
    rd(CTRL, 32'hFFFF_FFFF, "R2 readback ones");

    walk("R7 R8 walk all-ones ctrl");
    apply(14'h3A5C, 24'hFC_1234, 32'hDEAD_BEEF, "R4 R5 R6 ones mixed");

    wr(CTRL, 32'h0);
    walk("R7 R8 walk zero ctrl");

    wr(CTRL, 32'hA5A5_3C3C);
    rd(CTRL, 32'hA5A5_3C3C, "R2 readback pattern");
    apply(14'h2AAA, 24'h95_5555, 32'h5A5A_C3C3, "R4 R5 pattern mix 1");
    apply(14'h1555, 24'h6A_AAAA, 32'hA5A5_3C3C, "R4 R5 pattern mix 2");
    apply('0, 24'hFC_0000, '0, "R6 fixed lines");

    wr(8'h50, 32'h0000_0001);
    rd(8'h50, 32'h0, "R3 other addr read");
    rd(CTRL, 32'hA5A5_3C3C, "R3 register unchanged");
    apply(14'h0001, '0, 32'h1, "R3 routing unchanged");

    wr(CTRL, 32'h0000_4001);
    apply(14'h0001, 24'h00_0001, '0, "R4 R5 boundary bits");
    apply('0, '0, 32'h0000_4001, "R4 R5 boundary C");

    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 20000 && !done; t++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: done=0 expected=1");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule